// File: doc/BRIEF.md
# Station Address Table Loader

This block fills a small table of 48-bit station addresses by reading descriptors from system memory. Software supplies a descriptor pointer, the upper half of the memory address, an entry count and a data-width mode, then pulses a load command. The loader walks the descriptor list one entry at a time. For each entry it reads three halfword slots, splits them into six address bytes and writes the finished entry into the table. After the last entry it reads one more slot, which becomes a 16-bit per-entry enable mask.

When the walk ends, the busy (command) bit drops and a load-done status flag is set. The interrupt line is that flag gated by an enable input. Software clears the flag by writing one to it. The memory side is a simple port with a single read in flight: a one-cycle request with a 32-bit address, then a response strobe carrying data. The address comparator that uses the table, and the bus arbitration, live elsewhere.

Top module: `stn_tbl_loader`

## Requirements
- R1: A `load_req` pulse while idle captures count, pointer, base and mode, and `busy` is high on the following cycle. Table indices for each load start at 0 and rise by one per entry.
- R2: The number of entries is `load_count[4:0]`; the upper count bits have no effect. `remaining` starts at that value and drops by one on each table write.
- R3: Every read address is `{area_base, ptr + offset}` with 16-bit wrapping addition. A slot is 2 bytes in narrow mode (`wide_mode`=0) and 4 bytes in wide mode, and only `rd_rsp_data[15:0]` of a response is used. A descriptor is 4 slots, so the pointer advances 8 or 16 bytes per entry.
- R4: For an entry, slot 0 is never read. Slots 1, 2 and 3 are read in that order. Slot k supplies address byte 2(k-1) from its low byte and byte 2(k-1)+1 from its high byte, with byte j placed at `tbl_addr[8j+7:8j]`. Each entry produces exactly one `tbl_we` cycle.
- R5: After the last entry, slot 0 of the next descriptor is read and its halfword becomes `enable_mask`. With a count of 0, that single read is the only access.
- R6: `busy` falls and `done_flag` rises on the same clock edge, after the mask response, with no outstanding reads and no further table writes.
- R7: `irq` is high exactly when `done_flag` and `irq_en` are both high, including the cycle in which `done_flag` is first set.
- R8: `done_clr` clears `done_flag`. A completion in the same cycle takes priority and leaves the flag set.
- R9: A read response that arrives while no read is pending changes neither the table nor `enable_mask` nor `busy`.
- R10: A `load_req` while busy is ignored, and the running walk continues unchanged.
- R11: At most one read is outstanding. A new request is issued only after the previous response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Load command pulse |
| load_count | input | 16 | Entry count register (low CNT_W bits used) |
| load_ptr | input | 16 | Descriptor pointer, low address half |
| area_base | input | 16 | Upper address half |
| wide_mode | input | 1 | 1: 32-bit slots, 0: 16-bit slots |
| rd_req_valid | output | 1 | Memory read request strobe |
| rd_req_addr | output | 32 | Memory read byte address |
| rd_rsp_valid | input | 1 | Memory read response strobe |
| rd_rsp_data | input | BUS_W | Memory read data |
| tbl_we | output | 1 | Table write enable |
| tbl_idx | output | CNT_W | Table write index |
| tbl_addr | output | 48 | Station address to write |
| busy | output | 1 | Load command bit |
| remaining | output | CNT_W | Entries still to load |
| enable_mask | output | 16 | Per-entry enable mask |
| done_clr | input | 1 | Write-one-to-clear for done flag |
| irq_en | input | 1 | Interrupt enable for done flag |
| done_flag | output | 1 | Load-done status |
| irq | output | 1 | Interrupt request |

## Verification
A narrow-mode load of a few entries with one-cycle memory latency shows the slot order, the byte split and the 8-byte stride. A wide-mode load whose pointer wraps past 0xFFFF, with a slower memory, upper count bits set and garbage in the upper response halfword, separates the 16-byte stride, the 16-bit wrap and the count masking from the narrow case. A zero-count load, a maximum-count load, a reload issued mid-walk, a stray response while idle, and a clear held across completion each isolate one corner: the lone mask read, index range, command blocking, response gating and set-over-clear priority.

// File: rtl/stn_tbl_pkg.sv
package stn_tbl_pkg;

    localparam int HALF_W      = 16;
    localparam int ADDR_SLOTS  = 3;
    localparam int ENTRY_W     = ADDR_SLOTS * HALF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_COMMIT
    } ldr_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] base;
        logic [HALF_W-1:0] ptr;
        logic              wide;
    } job_t;

    // byte offset of a slot within a descriptor
    function automatic logic [HALF_W-1:0] slot_offset(input logic [1:0] slot, input logic wide);
        return wide ? {12'd0, slot, 2'b00} : {13'd0, slot, 1'b0};
    endfunction

    // bytes covered by one whole descriptor (four slots)
    function automatic logic [HALF_W-1:0] desc_stride(input logic wide);
        return wide ? 16'd16 : 16'd8;
    endfunction

endpackage

// File: rtl/stn_tbl_addr_gen.sv
module stn_tbl_addr_gen
    import stn_tbl_pkg::*;
(
    input  job_t        job,
    input  logic [1:0]  slot,
    output logic [31:0] addr
);
    logic [HALF_W-1:0] low_half;

    always_comb begin
        low_half = job.ptr + slot_offset(slot, job.wide);
        addr     = {job.base, low_half};
    end
endmodule

// File: rtl/stn_tbl_unpack.sv
module stn_tbl_unpack
    import stn_tbl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic [1:0]         cap_slot,
    input  logic [HALF_W-1:0]  cap_half,
    output logic [ENTRY_W-1:0] entry
);
    for (genvar g = 0; g < ADDR_SLOTS; g++) begin : g_half
        logic [HALF_W-1:0] half_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                half_q <= '0;
            end else if (cap_en && cap_slot == 2'(g + 1)) begin
                half_q <= cap_half;
            end
        end

        // low byte is the earlier address byte
        assign entry[g*HALF_W +: 8]     = half_q[7:0];
        assign entry[g*HALF_W + 8 +: 8] = half_q[15:8];
    end
endmodule

// File: rtl/stn_tbl_seq.sv
module stn_tbl_seq
    import stn_tbl_pkg::*;
#(
    parameter int CNT_W = 5
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_req,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [HALF_W-1:0] load_ptr,
    input  logic [HALF_W-1:0] load_base,
    input  logic              load_wide,
    input  logic              rsp_valid,
    input  logic [HALF_W-1:0] rsp_half,
    output logic              busy,
    output logic              req_valid,
    output job_t              job,
    output logic [1:0]        slot,
    output logic              cap_en,
    output logic              tbl_we,
    output logic [CNT_W-1:0]  tbl_idx,
    output logic [CNT_W-1:0]  remaining,
    output logic [HALF_W-1:0] mask,
    output logic              finish
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ldr_state_e        state_q;
    logic              mask_ph_q;
    logic [CNT_W-1:0]  idx_q;

    always_comb begin
        busy      = (state_q != ST_IDLE);
        req_valid = (state_q == ST_ISSUE);
        tbl_we    = (state_q == ST_COMMIT);
        cap_en    = (state_q == ST_AWAIT) && rsp_valid && !mask_ph_q;
        finish    = (state_q == ST_AWAIT) && rsp_valid && mask_ph_q;
        tbl_idx   = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mask_ph_q <= 1'b0;
            idx_q     <= '0;
            slot      <= '0;
            remaining <= '0;
            mask      <= '0;
            job       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load_req) begin
                        job.base  <= load_base;
                        job.ptr   <= load_ptr;
                        job.wide  <= load_wide;
                        remaining <= load_cnt;
                        idx_q     <= '0;
                        if (load_cnt != '0) begin
                            slot      <= 2'd1;
                            mask_ph_q <= 1'b0;
                        end else begin
                            slot      <= 2'd0;
                            mask_ph_q <= 1'b1;
                        end
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (rsp_valid) begin
                        if (mask_ph_q) begin
                            mask    <= rsp_half;
                            state_q <= ST_IDLE;
                        end else if (slot == 2'd3) begin
                            state_q <= ST_COMMIT;
                        end else begin
                            slot    <= slot + 2'd1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_COMMIT: begin
                    remaining <= remaining - CNT_ONE;
                    idx_q     <= idx_q + CNT_ONE;
                    job.ptr   <= job.ptr + desc_stride(job.wide);
                    if (remaining == CNT_ONE) begin
                        slot      <= 2'd0;
                        mask_ph_q <= 1'b1;
                    end else begin
                        slot      <= 2'd1;
                    end
                    state_q <= ST_ISSUE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stn_tbl_status.sv
module stn_tbl_status (
    input  logic clk,
    input  logic rst,
    input  logic finish,
    input  logic clr,
    input  logic irq_en,
    output logic done_flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
        end else if (finish) begin
            done_flag <= 1'b1;
        end else if (clr) begin
            done_flag <= 1'b0;
        end
    end

    assign irq = done_flag & irq_en;
endmodule

// File: rtl/stn_tbl_loader.sv
module stn_tbl_loader
    import stn_tbl_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int BUS_W = 32
)
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_req,
    input  logic [15:0]        load_count,
    input  logic [15:0]        load_ptr,
    input  logic [15:0]        area_base,
    input  logic               wide_mode,
    output logic               rd_req_valid,
    output logic [31:0]        rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [BUS_W-1:0]   rd_rsp_data,
    output logic               tbl_we,
    output logic [CNT_W-1:0]   tbl_idx,
    output logic [ENTRY_W-1:0] tbl_addr,
    output logic               busy,
    output logic [CNT_W-1:0]   remaining,
    output logic [15:0]        enable_mask,
    input  logic               done_clr,
    input  logic               irq_en,
    output logic               done_flag,
    output logic               irq
);
    job_t        job;
    logic [1:0]  slot;
    logic        cap_en;
    logic        finish;
    logic        unused_hi;

    assign unused_hi = ^{load_count[15:CNT_W], rd_rsp_data[BUS_W-1:HALF_W]};

    stn_tbl_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_req  (load_req),
        .load_cnt  (load_count[CNT_W-1:0]),
        .load_ptr  (load_ptr),
        .load_base (area_base),
        .load_wide (wide_mode),
        .rsp_valid (rd_rsp_valid),
        .rsp_half  (rd_rsp_data[HALF_W-1:0]),
        .busy      (busy),
        .req_valid (rd_req_valid),
        .job       (job),
        .slot      (slot),
        .cap_en    (cap_en),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .remaining (remaining),
        .mask      (enable_mask),
        .finish    (finish)
    );

    stn_tbl_addr_gen u_addr (
        .job  (job),
        .slot (slot),
        .addr (rd_req_addr)
    );

    stn_tbl_unpack u_unpack (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_slot (slot),
        .cap_half (rd_rsp_data[HALF_W-1:0]),
        .entry    (tbl_addr)
    );

    stn_tbl_status u_status (
        .clk       (clk),
        .rst       (rst),
        .finish    (finish),
        .clr       (done_clr),
        .irq_en    (irq_en),
        .done_flag (done_flag),
        .irq       (irq)
    );
endmodule

// File: rtl/stn_tbl_loader_chk.sv
module stn_tbl_loader_chk #(
    parameter int CNT_W = 5
)
(
    input logic             clk,
    input logic             rst,
    input logic             load_req,
    input logic             busy,
    input logic             rd_req_valid,
    input logic             rd_rsp_valid,
    input logic             tbl_we,
    input logic [CNT_W-1:0] remaining,
    input logic             done_flag,
    input logic             irq,
    input logic [15:0]      enable_mask
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (rd_req_valid) begin
            pend_q <= 1'b1;
        end else if (rd_rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_req) |=> busy); // R1
    AST_REMAIN_DEC: assert property (@(posedge clk) disable iff (rst)
        tbl_we |=> (remaining == $past(remaining) - CNT_W'(1))); // R2
    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> busy); // R6
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_flag); // R6
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> done_flag); // R7
    AST_MASK_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load_req) |=> $stable(enable_mask)); // R9
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> busy); // R11
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> !pend_q); // R11
endmodule

bind stn_tbl_loader stn_tbl_loader_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_req     (load_req),
    .busy         (busy),
    .rd_req_valid (rd_req_valid),
    .rd_rsp_valid (rd_rsp_valid),
    .tbl_we       (tbl_we),
    .remaining    (remaining),
    .done_flag    (done_flag),
    .irq          (irq),
    .enable_mask  (enable_mask)
);

// File: tb/stn_tbl_loader_bench.sv
module stn_tbl_loader_bench;
    localparam int CNT_W = 5;
    localparam int BUS_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_req = 1'b0;
    logic [15:0]       load_count = '0;
    logic [15:0]       load_ptr = '0;
    logic [15:0]       area_base = '0;
    logic              wide_mode = 1'b0;
    logic              rd_req_valid;
    logic [31:0]       rd_req_addr;
    logic              rd_rsp_valid = 1'b0;
    logic [BUS_W-1:0]  rd_rsp_data = '0;
    logic              tbl_we;
    logic [CNT_W-1:0]  tbl_idx;
    logic [47:0]       tbl_addr;
    logic              busy;
    logic [CNT_W-1:0]  remaining;
    logic [15:0]       enable_mask;
    logic              done_clr = 1'b0;
    logic              irq_en = 1'b0;
    logic              done_flag;
    logic              irq;

    always #2.5 clk = ~clk;

    stn_tbl_loader #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_stn_tbl_loader (.*);

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [31:0] exp_addr[$];
    int          exp_idx[$];
    logic [47:0] exp_ent[$];
    int          exp_rem[$];
    logic [15:0] exp_mask = '0;
    int          lat = 1;
    bit          stray = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] memf(input logic [31:0] a);
        return a[15:0] ^ a[31:16] ^ 16'h6C35 ^ {a[7:0], a[15:8]};
    endfunction

    // memory responder and per-cycle comparison against the model
    initial begin
        bit          pend = 1'b0;
        int          pcnt = 0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (stray) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = 32'hDEAD_BEEF;
                stray = 1'b0;
            end
            if (pend) begin
                if (pcnt <= 1) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = {~memf(paddr), memf(paddr)};
                    pend = 1'b0;
                end else begin
                    pcnt--;
                end
            end
            if (rd_req_valid) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R3", "unexpected read", 64'(rd_req_addr), 64'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea;
                    ea = exp_addr.pop_front();
                    chk(rd_req_addr == ea, "R3", "read address", 64'(rd_req_addr), 64'(ea));
                end
                pend  = 1'b1;
                pcnt  = lat;
                paddr = rd_req_addr;
            end
            if (tbl_we) begin
                if (exp_idx.size() == 0) begin
                    chk(1'b0, "R4", "unexpected table write", 64'(tbl_idx), 64'hFF);
                end else begin
                    int          ei;
                    int          er;
                    logic [47:0] ee;
                    ei = exp_idx.pop_front();
                    ee = exp_ent.pop_front();
                    er = exp_rem.pop_front();
                    chk(int'(tbl_idx) == ei, "R1", "table index", 64'(tbl_idx), 64'(ei));
                    chk(tbl_addr == ee, "R4", "table entry", 64'(tbl_addr), 64'(ee));
                    chk(int'(remaining) == er, "R2", "remaining at write", 64'(remaining), 64'(er));
                end
            end
        end
    end

    task automatic plan_load(input logic [15:0] cnt, input logic [15:0] ptr,
                             input logic [15:0] base, input bit wide);
        int          n;
        logic [15:0] sb;
        logic [15:0] st;
        logic [15:0] p;
        n  = int'(cnt[4:0]);
        sb = wide ? 16'd4 : 16'd2;
        st = wide ? 16'd16 : 16'd8;
        p  = ptr;
        for (int e = 0; e < n; e++) begin
            logic [15:0] h1, h2, h3;
            h1 = memf({base, 16'(p + sb)});
            h2 = memf({base, 16'(p + 2*sb)});
            h3 = memf({base, 16'(p + 3*sb)});
            exp_addr.push_back({base, 16'(p + sb)});
            exp_addr.push_back({base, 16'(p + 2*sb)});
            exp_addr.push_back({base, 16'(p + 3*sb)});
            exp_idx.push_back(e);
            exp_ent.push_back({h3[15:8], h3[7:0], h2[15:8], h2[7:0], h1[15:8], h1[7:0]});
            exp_rem.push_back(n - e);
            p = p + st;
        end
        exp_addr.push_back({base, p});
        exp_mask = memf({base, p});
    endtask

    task automatic start_load(input logic [15:0] cnt, input logic [15:0] ptr,
                              input logic [15:0] base, input bit wide, input int l);
        plan_load(cnt, ptr, base, wide);
        lat = l;
        @(negedge clk);
        load_count = cnt; load_ptr = ptr; area_base = base; wide_mode = wide;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        chk(busy == 1'b1, "R1", "busy after load", 64'(busy), 64'd1);
        // scramble inputs: captured values must be used
        load_ptr = ~ptr; area_base = ~base; wide_mode = ~wide; load_count = 16'h0;
    endtask

    task automatic finish_load(input string tag);
        while (busy) @(negedge clk);
        chk(exp_addr.size() == 0, "R6", {tag, " reads left"}, 64'(exp_addr.size()), 64'd0);
        chk(exp_idx.size() == 0, "R6", {tag, " writes left"}, 64'(exp_idx.size()), 64'd0);
        chk(enable_mask == exp_mask, "R5", {tag, " mask"}, 64'(enable_mask), 64'(exp_mask));
        chk(done_flag == 1'b1, "R6", {tag, " done"}, 64'(done_flag), 64'd1);
        chk(irq == irq_en, "R7", {tag, " irq"}, 64'(irq), 64'(irq_en));
        chk(remaining == '0, "R2", {tag, " remaining"}, 64'(remaining), 64'd0);
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk(done_flag == 1'b0, "R8", "done cleared", 64'(done_flag), 64'd0);
        chk(irq == 1'b0, "R7", "irq after clear", 64'(irq), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
        chk(done_flag == 1'b0, "R6", "reset done", 64'(done_flag), 64'd0);
        chk(irq == 1'b0 && rd_req_valid == 1'b0 && tbl_we == 1'b0, "R11", "reset strobes",
            64'({irq, rd_req_valid, tbl_we}), 64'd0);
        chk(remaining == '0, "R2", "reset remaining", 64'(remaining), 64'd0);

        // narrow mode, three entries, fast memory, interrupt enabled
        irq_en = 1'b1;
        start_load(16'h0003, 16'h0100, 16'h1234, 1'b0, 1);
        finish_load("narrow3");
        clear_done();

        // wide mode, pointer wraps, upper count bits set, slow memory, irq off
        irq_en = 1'b0;
        start_load(16'hFFE2, 16'hFFF0, 16'hBEEF, 1'b1, 3);
        finish_load("wide_wrap");
        clear_done();

        // zero count: only the mask read
        start_load(16'h0020, 16'h0440, 16'h0007, 1'b0, 2);
        finish_load("zero");
        clear_done();

        // reload while busy is ignored (R10)
        irq_en = 1'b1;
        start_load(16'h0002, 16'h2000, 16'h00A0, 1'b1, 2);
        @(negedge clk);
        load_count = 16'h0005; load_ptr = 16'h7777; area_base = 16'h5555;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        finish_load("R10 reload");
        clear_done();

        // stray response while idle is ignored (R9)
        begin
            logic [15:0] old_mask;
            old_mask = enable_mask;
            @(posedge clk); #1 stray = 1'b1;
            repeat (3) @(negedge clk);
            chk(enable_mask == old_mask, "R9", "mask after stray", 64'(enable_mask), 64'(old_mask));
            chk(busy == 1'b0, "R9", "busy after stray", 64'(busy), 64'd0);
        end

        // clear held across completion: set wins (R8)
        start_load(16'h0001, 16'h0300, 16'h0042, 1'b0, 1);
        done_clr = 1'b1;
        while (busy) @(negedge clk);
        chk(done_flag == 1'b1, "R8", "set over clear", 64'(done_flag), 64'd1);
        @(negedge clk);
        chk(done_flag == 1'b0, "R8", "clear after set", 64'(done_flag), 64'd0);
        done_clr = 1'b0;
        chk(enable_mask == exp_mask, "R5", "mask single", 64'(enable_mask), 64'(exp_mask));

        // maximum count, index restarts at 0
        start_load(16'h001F, 16'h8000, 16'hC0DE, 1'b0, 1);
        finish_load("max");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule